// File: doc/BRIEF.md
# SPI Flash Opcode-Menu Cycle Engine

This block runs one serial-flash command at a time on a single-bit SPI link with one chip select. Host software does not hand the engine a raw opcode. It fills a table of eight opcodes, tags each entry with a two-bit kind, and then writes a control word. That word picks a table entry, says whether a data phase follows, gives the byte count, and can ask for an atomic prefix. The engine then shifts out the opcode, a 24-bit address when the entry's kind calls for one, and up to 64 data bytes. Write data comes from a 64-byte buffer, and read data is stored back into that same buffer.

The atomic prefix sends a stored write-enable opcode as its own chip-select frame. The main frame follows after a short idle gap, and no other command can run in between. A sticky lock bit freezes the opcode table, the kind register and the prefix register, so software that runs later can only issue commands the table already holds. The host side is a plain register bus: writes take effect in one cycle and reads are combinational. Every signal is a plain control or status pin, and there is no streaming handshake.

Top module: `spi_menu_engine`

## Requirements
- R1: After reset the status word reads 0, chip select is high and the SPI clock is low.
- R2: The first byte of every main frame is the opcode held in table entry `ctrl[6:4]`. Word 3 holds entries 0 to 3 and word 4 holds entries 4 to 7, with entry 4k+b in bits [8b+7:8b]. Word 5 holds entry i's kind in bits [2i+1:2i]. A kind's bit 1 set means the frame carries an address and bit 0 set means it writes. So 0 is a read with no address, 1 a write with no address, 2 a read with address and 3 a write with address.
- R3: When the kind carries an address, the opcode is followed by bits 23:0 of word 2, most significant byte first. Bits 31:24 are never sent.
- R4: When the data-enable bit `ctrl[2]` is clear, the frame holds only the opcode, plus the three address bytes when the kind asks for them.
- R5: A write with data sends `ctrl[13:8]`+1 bytes (1 to 64) taken from the buffer starting at byte 0, each most significant bit first. Buffer word 16+w holds bytes 4w to 4w+3, with byte 4w+b in bits [8b+7:8b].
- R6: A read with data stores the `ctrl[13:8]`+1 bytes that follow the header into the buffer, starting at byte 0.
- R7: Status word 1 has bit 0 for busy, bit 1 for done and bit 2 for error. Done is set when a cycle ends. Writing 1 to bit 1 or bit 2 clears that flag.
- R8: Writing the go bit `ctrl[0]` while busy does not change the cycle in flight and sets the error flag.
- R9: With `ctrl[1]` set, the 8-bit opcode in word 6 goes out first as a one-byte frame. Chip select then stays high for at least one SPI clock period before the main frame begins.
- R10: Once bit 0 of word 7 is written as 1, it stays set until reset, and writes to words 3, 4, 5 and 6 leave them unchanged.
- R11: The link runs in SPI mode 0. The clock idles low while chip select is high, and each clock phase lasts word 8 + 1 system clocks.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_wen | input | 1 | Register write strobe |
| reg_addr | input | 5 | Word address; 16 to 31 select the data buffer |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Combinational read data for reg_addr |
| spi_sclk | output | 1 | SPI clock |
| spi_cs_n | output | 1 | Chip select, active low |
| spi_mosi | output | 1 | Serial data to the flash |
| spi_miso | input | 1 | Serial data from the flash |

## Verification
The assertions assume the host writes no buffer word while a cycle is running, so only the engine fills the buffer during a read. They also assume the go bit arrives only through whole control-word writes. The stimulus keeps to these rules: it refills the buffer only after the done flag is seen, and its single go-while-busy write is a complete control word. The flash model in the bench samples on rising edges and changes data after them, which matches the mode-0 timing the checks rely on.

// File: rtl/spim_pkg.sv
package spim_pkg;
  typedef enum logic [1:0] {
    KIND_RD    = 2'd0,
    KIND_WR    = 2'd1,
    KIND_RD_AD = 2'd2,
    KIND_WR_AD = 2'd3
  } kind_e;

  typedef enum logic [2:0] {
    S_IDLE, S_PLOAD, S_PWAIT, S_GAP, S_LOAD, S_WAIT, S_TAIL
  } seq_state_e;

  localparam int unsigned A_CTRL   = 0;
  localparam int unsigned A_STAT   = 1;
  localparam int unsigned A_ADDR   = 2;
  localparam int unsigned A_MENU_L = 3;
  localparam int unsigned A_MENU_H = 4;
  localparam int unsigned A_KIND   = 5;
  localparam int unsigned A_PREFIX = 6;
  localparam int unsigned A_LOCK   = 7;
  localparam int unsigned A_DIV    = 8;
endpackage

// File: rtl/spim_shift.sv
module spim_shift #(
  parameter int unsigned DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic [DW-1:0] tx,
  input  logic [7:0]    div,
  input  logic          miso,
  output logic          sclk,
  output logic          mosi,
  output logic          done,
  output logic [DW-1:0] rx
);
  localparam int unsigned PW = $clog2(2 * DW);
  localparam logic [PW-1:0] PH_LAST = PW'(2 * DW - 1);

  logic          act;
  logic [7:0]    cnt;
  logic [PW-1:0] ph;
  logic [DW-1:0] sh;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      act  <= 1'b0;
      cnt  <= '0;
      ph   <= '0;
      sh   <= '0;
      rx   <= '0;
      sclk <= 1'b0;
      done <= 1'b0;
    end else begin
      done <= 1'b0;
      if (start) begin
        act  <= 1'b1;
        sh   <= tx;
        cnt  <= '0;
        ph   <= '0;
        sclk <= 1'b0;
      end else if (act) begin
        if (cnt == div) begin
          cnt <= '0;
          ph  <= ph + 1'b1;
          if (!ph[0]) begin
            sclk <= 1'b1;
            rx   <= {rx[DW-2:0], miso};
          end else begin
            sclk <= 1'b0;
            sh   <= {sh[DW-2:0], 1'b0};
          end
          if (ph == PH_LAST) begin
            act  <= 1'b0;
            done <= 1'b1;
          end
        end else begin
          cnt <= cnt + 1'b1;
        end
      end
    end
  end

  assign mosi = sh[DW-1];

  // R11: a byte always ends on a falling edge
  a_r11_done_clock_low: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !sclk);
  // R11: a clock phase never shortens below the divider setting
  a_r11_phase_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (act && !start && cnt != div) |=> $stable(sclk));
endmodule

// File: rtl/spim_seq.sv
module spim_seq
  import spim_pkg::*;
#(
  parameter int unsigned BUF_BYTES = 64,
  parameter int unsigned CW = $clog2(BUF_BYTES)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          go,
  input  logic          atomic,
  input  logic          den,
  input  logic [CW-1:0] cnt_m1,
  input  logic [7:0]    opcode,
  input  logic [1:0]    kind,
  input  logic [23:0]   addr,
  input  logic [7:0]    prefix,
  input  logic [7:0]    div,
  input  logic          sh_done,
  input  logic [7:0]    sh_rx,
  input  logic [7:0]    buf_rd,
  output logic          busy,
  output logic          cyc_done,
  output logic          cs_n,
  output logic          sh_start,
  output logic [7:0]    sh_tx,
  output logic          buf_we,
  output logic [CW-1:0] buf_idx,
  output logic [7:0]    buf_wd
);
  localparam int unsigned KW = $clog2(BUF_BYTES + 5);

  seq_state_e    st;
  logic [7:0]    op_q, pre_q;
  logic [1:0]    kind_q;
  logic [23:0]   ad_q;
  logic          den_q;
  logic [KW-1:0] n_q, k;
  logic [8:0]    gcnt;
  logic [8:0]    glen;
  logic [KW-1:0] hdr, total;

  assign glen  = ({1'b0, div} + 9'd1) << 1;
  assign hdr   = kind_q[1] ? KW'(4) : KW'(1);
  assign total = hdr + (den_q ? n_q : '0);

  assign busy     = (st != S_IDLE);
  assign sh_start = (st == S_PLOAD) || (st == S_LOAD);
  assign buf_idx  = CW'(k - hdr);
  assign buf_we   = (st == S_WAIT) && sh_done && !kind_q[0] && (k >= hdr);
  assign buf_wd   = sh_rx;

  always_comb begin
    sh_tx = 8'h00;
    if (st == S_PLOAD)                 sh_tx = pre_q;
    else if (k == '0)                  sh_tx = op_q;
    else if (kind_q[1] && k == KW'(1)) sh_tx = ad_q[23:16];
    else if (kind_q[1] && k == KW'(2)) sh_tx = ad_q[15:8];
    else if (kind_q[1] && k == KW'(3)) sh_tx = ad_q[7:0];
    else if (kind_q[0])                sh_tx = buf_rd;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st       <= S_IDLE;
      op_q     <= '0;
      pre_q    <= '0;
      kind_q   <= '0;
      ad_q     <= '0;
      den_q    <= 1'b0;
      n_q      <= '0;
      k        <= '0;
      gcnt     <= '0;
      cs_n     <= 1'b1;
      cyc_done <= 1'b0;
    end else begin
      cyc_done <= 1'b0;
      case (st)
        S_IDLE: if (go) begin
          op_q   <= opcode;
          pre_q  <= prefix;
          kind_q <= kind;
          ad_q   <= addr;
          den_q  <= den;
          n_q    <= KW'(cnt_m1) + 1'b1;
          k      <= '0;
          cs_n   <= 1'b0;
          st     <= atomic ? S_PLOAD : S_LOAD;
        end
        S_PLOAD: st <= S_PWAIT;
        S_PWAIT: if (sh_done) begin
          cs_n <= 1'b1;
          gcnt <= '0;
          st   <= S_GAP;
        end
        S_GAP: begin
          gcnt <= gcnt + 1'b1;
          if (gcnt == glen - 9'd1) begin
            cs_n <= 1'b0;
            st   <= S_LOAD;
          end
        end
        S_LOAD: st <= S_WAIT;
        S_WAIT: if (sh_done) begin
          if (k == total - 1'b1) begin
            cs_n <= 1'b1;
            gcnt <= '0;
            st   <= S_TAIL;
          end else begin
            k  <= k + 1'b1;
            st <= S_LOAD;
          end
        end
        S_TAIL: begin
          gcnt <= gcnt + 1'b1;
          if (gcnt == glen - 9'd1) begin
            cyc_done <= 1'b1;
            st       <= S_IDLE;
          end
        end
        default: st <= S_IDLE;
      endcase
    end
  end

  // R8: a go during a cycle leaves the latched command untouched
  a_r8_cmd_frozen: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && go) |=> ($stable(op_q) && $stable(kind_q) && $stable(ad_q)));
  // R9: chip select is high throughout the inter-frame gap
  a_r9_gap_cs_high: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_GAP) |-> cs_n);
endmodule

// File: rtl/spi_menu_engine.sv
module spi_menu_engine
  import spim_pkg::*;
#(
  parameter int unsigned BUF_BYTES = 64,
  parameter int unsigned MENU_N    = 8,
  localparam int unsigned WORDS    = BUF_BYTES / 4,
  localparam int unsigned WIW      = $clog2(WORDS),
  localparam int unsigned AW       = WIW + 1,
  localparam int unsigned CW       = $clog2(BUF_BYTES),
  localparam int unsigned IW       = $clog2(MENU_N)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          reg_wen,
  input  logic [AW-1:0] reg_addr,
  input  logic [31:0]   reg_wdata,
  output logic [31:0]   reg_rdata,
  output logic          spi_sclk,
  output logic          spi_cs_n,
  output logic          spi_mosi,
  input  logic          spi_miso
);
  logic [7:0]          menu [MENU_N];
  logic [8*MENU_N-1:0] menu_p;
  logic [2*MENU_N-1:0] kind_q;
  logic [7:0]          prefix_q, div_q;
  logic [31:0]         addr_q;
  logic                lock_q, done_f, err_f;
  logic [7:0]          bufm [BUF_BYTES];
  logic [31:0]         buf_word;

  logic          busy, seq_done, sh_start, sh_done, buf_we;
  logic [7:0]    sh_tx, sh_rx, buf_wd;
  logic [CW-1:0] buf_idx;

  logic          w_ctrl, w_stat, go, is_buf;
  logic [IW-1:0] ci;
  logic [WIW-1:0] widx;

  assign is_buf = reg_addr[AW-1];
  assign widx   = reg_addr[WIW-1:0];
  assign w_ctrl = reg_wen && !is_buf && (reg_addr == AW'(A_CTRL));
  assign w_stat = reg_wen && !is_buf && (reg_addr == AW'(A_STAT));
  assign go     = w_ctrl && reg_wdata[0];
  assign ci     = reg_wdata[4 +: IW];

  for (genvar i = 0; i < MENU_N; i++) begin : g_menu_pack
    assign menu_p[8*i +: 8] = menu[i];
  end
  for (genvar b = 0; b < 4; b++) begin : g_lane
    assign buf_word[8*b +: 8] = bufm[{widx, 2'(b)}];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < MENU_N; i++) menu[i] <= '0;
      kind_q   <= '0;
      prefix_q <= '0;
      div_q    <= '0;
      addr_q   <= '0;
      lock_q   <= 1'b0;
      done_f   <= 1'b0;
      err_f    <= 1'b0;
    end else begin
      if (reg_wen && !is_buf) begin
        case (int'(reg_addr))
          A_ADDR:   addr_q <= reg_wdata;
          A_MENU_L: if (!lock_q) for (int b = 0; b < 4; b++) menu[b] <= reg_wdata[8*b +: 8];
          A_MENU_H: if (!lock_q) for (int b = 0; b < 4; b++) menu[4+b] <= reg_wdata[8*b +: 8];
          A_KIND:   if (!lock_q) kind_q <= reg_wdata[2*MENU_N-1:0];
          A_PREFIX: if (!lock_q) prefix_q <= reg_wdata[7:0];
          A_LOCK:   lock_q <= lock_q | reg_wdata[0];
          A_DIV:    div_q <= reg_wdata[7:0];
          default: ;
        endcase
      end
      done_f <= (done_f & ~(w_stat & reg_wdata[1])) | seq_done;
      err_f  <= (err_f & ~(w_stat & reg_wdata[2])) | (go & busy);
    end
  end

  always_ff @(posedge clk) begin
    if (reg_wen && is_buf)
      for (int b = 0; b < 4; b++) bufm[{widx, 2'(b)}] <= reg_wdata[8*b +: 8];
    if (buf_we) bufm[buf_idx] <= buf_wd;
  end

  always_comb begin
    reg_rdata = 32'h0;
    if (is_buf) reg_rdata = buf_word;
    else case (int'(reg_addr))
      A_STAT:   reg_rdata = {29'h0, err_f, done_f, busy};
      A_ADDR:   reg_rdata = addr_q;
      A_MENU_L: reg_rdata = menu_p[31:0];
      A_MENU_H: reg_rdata = menu_p[63:32];
      A_KIND:   reg_rdata = 32'(kind_q);
      A_PREFIX: reg_rdata = {24'h0, prefix_q};
      A_LOCK:   reg_rdata = {31'h0, lock_q};
      A_DIV:    reg_rdata = {24'h0, div_q};
      default:  reg_rdata = 32'h0;
    endcase
  end

  spim_seq #(.BUF_BYTES(BUF_BYTES), .CW(CW)) u_seq (
    .clk      (clk),
    .rst_n    (rst_n),
    .go       (go),
    .atomic   (reg_wdata[1]),
    .den      (reg_wdata[2]),
    .cnt_m1   (reg_wdata[8 +: CW]),
    .opcode   (menu[ci]),
    .kind     (kind_q[{ci, 1'b0} +: 2]),
    .addr     (addr_q[23:0]),
    .prefix   (prefix_q),
    .div      (div_q),
    .sh_done  (sh_done),
    .sh_rx    (sh_rx),
    .buf_rd   (bufm[buf_idx]),
    .busy     (busy),
    .cyc_done (seq_done),
    .cs_n     (spi_cs_n),
    .sh_start (sh_start),
    .sh_tx    (sh_tx),
    .buf_we   (buf_we),
    .buf_idx  (buf_idx),
    .buf_wd   (buf_wd)
  );

  spim_shift #(.DW(8)) u_shift (
    .clk   (clk),
    .rst_n (rst_n),
    .start (sh_start),
    .tx    (sh_tx),
    .div   (div_q),
    .miso  (spi_miso),
    .sclk  (spi_sclk),
    .mosi  (spi_mosi),
    .done  (sh_done),
    .rx    (sh_rx)
  );

  // R7: the end of a cycle always leaves the done flag raised
  a_r7_done_latched: assert property (@(posedge clk) disable iff (!rst_n)
    seq_done |=> done_f);
  // R8: a go while busy raises the error flag
  a_r8_busy_go_err: assert property (@(posedge clk) disable iff (!rst_n)
    (go && busy) |=> err_f);
  // R10: a locked table ignores writes
  a_r10_menu_locked: assert property (@(posedge clk) disable iff (!rst_n)
    (lock_q && reg_wen && !is_buf && (reg_addr == AW'(A_MENU_L) || reg_addr == AW'(A_MENU_H)))
      |=> $stable(menu_p));
  // R11: clock idles low whenever chip select is released
  a_r11_idle_low: assert property (@(posedge clk) disable iff (!rst_n)
    spi_cs_n |-> !spi_sclk);
endmodule

// File: tb/sim_spi_menu_engine.sv
module sim_spi_menu_engine;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_wen = 1'b0;
  logic [4:0]  reg_addr = '0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic        spi_sclk, spi_cs_n, spi_mosi, spi_miso;

  int checks = 0;
  int failures = 0;

  always #5 clk = ~clk;

  spi_menu_engine u0 (
    .clk(clk), .rst_n(rst_n), .reg_wen(reg_wen), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .spi_sclk(spi_sclk),
    .spi_cs_n(spi_cs_n), .spi_mosi(spi_mosi), .spi_miso(spi_miso)
  );

  function automatic logic [7:0] pat(input int j);
    return 8'((j * 37 + 8'h5A) & 8'hFF);
  endfunction
  function automatic logic [7:0] wp(input int i);
    return 8'((i * 11 + 3) & 8'hFF);
  endfunction
  function automatic logic [7:0] mop(input int i);
    return 8'((8'h03 + i * 8'h1D) & 8'hFF);
  endfunction

  // flash model
  int cyc = 0;
  int frames = 0;
  int cur = 0;
  int bitcnt = 0;
  int rise_cs = 0;
  int rise_ck = 0;
  int hp = 0;
  int fn [4];
  int gap [4];
  logic [7:0] sh = '0;
  logic [7:0] fb [4][80];

  always @(negedge clk) cyc <= cyc + 1;
  always @(posedge spi_cs_n) rise_cs = cyc;
  always @(negedge spi_cs_n) begin
    cur = frames % 4;
    gap[cur] = cyc - rise_cs;
    fn[cur] = 0;
    bitcnt = 0;
    frames = frames + 1;
  end
  always @(posedge spi_sclk) if (!spi_cs_n) begin
    sh = {sh[6:0], spi_mosi};
    bitcnt = bitcnt + 1;
    rise_ck = cyc;
    if (bitcnt % 8 == 0 && fn[cur] < 80) begin
      fb[cur][fn[cur]] = sh;
      fn[cur] = fn[cur] + 1;
    end
  end
  always @(negedge spi_sclk) hp = cyc - rise_ck;
  assign spi_miso = pat(bitcnt / 8)[7 - (bitcnt % 8)];

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wr(input int a, input logic [31:0] d);
    @(negedge clk);
    reg_addr = 5'(a); reg_wdata = d; reg_wen = 1'b1;
    @(negedge clk);
    reg_wen = 1'b0;
  endtask

  task automatic rd(input int a, output logic [31:0] d);
    @(negedge clk);
    reg_addr = 5'(a); reg_wen = 1'b0;
    #1 d = reg_rdata;
  endtask

  task automatic wait_done(input string req);
    logic [31:0] s;
    int n = 0;
    rd(1, s);
    while (!s[1] && n < 20000) begin rd(1, s); n++; end
    chk(s[1], req, s, 2);
  endtask

  task automatic fill_buf();
    for (int w = 0; w < 16; w++)
      wr(16 + w, {wp(4*w+3), wp(4*w+2), wp(4*w+1), wp(4*w)});
  endtask

  task automatic run(input int idx, input int kind, input int n, input bit den,
                     input bit atomic, input int div);
    int f0, hdr, len, m, bad;
    logic [31:0] ad, s, d;
    fill_buf();
    wr(5, 32'(kind) << (2 * idx));
    ad = 32'hA5000000 | (idx << 16) | (kind << 8) | n;
    wr(2, ad);
    f0 = frames;
    wr(0, {18'h0, 6'(n - 1), 1'b0, 3'(idx), 1'b0, den, atomic, 1'b1});
    wait_done("R7");
    hdr = kind[1] ? 4 : 1;
    len = hdr + (den ? n : 0);
    chk(frames - f0 == (atomic ? 2 : 1), "R9", frames - f0, atomic ? 2 : 1);
    m = (frames - 1) % 4;
    chk(fn[m] == len, den ? "R5" : "R4", fn[m], len);
    chk(fb[m][0] == mop(idx), "R2", fb[m][0], mop(idx));
    if (kind[1])
      chk({fb[m][1], fb[m][2], fb[m][3]} == ad[23:0], "R3",
          {fb[m][1], fb[m][2], fb[m][3]}, ad[23:0]);
    if (den && kind[0]) begin
      bad = 0;
      for (int i = 0; i < n; i++) if (fb[m][hdr + i] !== wp(i)) bad++;
      chk(bad == 0, "R5", bad, 0);
    end
    if (den && !kind[0]) begin
      bad = 0;
      for (int w = 0; w < 16; w++) begin
        rd(16 + w, d);
        for (int b = 0; b < 4; b++)
          if (4*w + b < n && d[8*b +: 8] !== pat(hdr + 4*w + b)) bad++;
      end
      chk(bad == 0, "R6", bad, 0);
    end
    if (atomic) begin
      int p = (frames - 2) % 4;
      chk(fn[p] == 1 && fb[p][0] == 8'h06, "R9", fb[p][0], 8'h06);
      chk(gap[m] >= 2 * (div + 1), "R9", gap[m], 2 * (div + 1));
    end
    chk(hp == div + 1, "R11", hp, div + 1);
    wr(1, 32'h6);
    rd(1, s);
    chk(s == 0, "R7", s, 0);
  endtask

  task automatic tests();
    logic [31:0] s, d;
    int f0, m;
    rd(1, s);
    chk(s == 0 && spi_cs_n && !spi_sclk, "R1", s, 0);
    wr(3, {mop(3), mop(2), mop(1), mop(0)});
    wr(4, {mop(7), mop(6), mop(5), mop(4)});
    wr(6, 32'h06);
    wr(8, 0);
    for (int idx = 0; idx < 8; idx++)
      for (int k = 0; k < 4; k++)
        run(idx, k, ((idx * 9 + k * 5) % 64) + 1, ((idx + k) % 3) != 0,
            (idx % 2 == 1) && k[0], 0);
    run(1, 3, 64, 1'b1, 1'b0, 0);
    run(2, 2, 64, 1'b1, 1'b0, 0);
    run(6, 1, 1, 1'b1, 1'b1, 0);
    wr(8, 3);
    run(4, 3, 3, 1'b1, 1'b1, 3);
    wr(8, 0);
    // R8: go while busy
    wr(5, 32'h3 << 4);
    wr(2, 32'h00123456);
    f0 = frames;
    wr(0, {18'h0, 6'd63, 1'b0, 3'd2, 4'b0101});
    repeat (20) @(negedge clk);
    wr(0, {18'h0, 6'd0, 1'b0, 3'd5, 4'b0001});
    rd(1, s);
    chk(s[2] && s[0], "R8", s, 5);
    wait_done("R8");
    m = (frames - 1) % 4;
    chk(frames - f0 == 1 && fb[m][0] == mop(2) && fn[m] == 68, "R8", fb[m][0], mop(2));
    wr(1, 32'h6);
    rd(1, s);
    chk(s == 0, "R7", s, 0);
    // R10: lock
    wr(7, 1);
    wr(3, 32'hFFFFFFFF);
    wr(4, 32'hFFFFFFFF);
    wr(5, 32'hFFFF);
    wr(6, 32'hFF);
    wr(7, 0);
    rd(3, d);
    chk(d == {mop(3), mop(2), mop(1), mop(0)}, "R10", d, {mop(3), mop(2), mop(1), mop(0)});
    rd(4, d);
    chk(d == {mop(7), mop(6), mop(5), mop(4)}, "R10", d, {mop(7), mop(6), mop(5), mop(4)});
    rd(5, d);
    chk(d == (32'h3 << 4), "R10", d, 32'h30);
    rd(6, d);
    chk(d == 32'h06, "R10", d, 32'h06);
    rd(7, d);
    chk(d == 1, "R10", d, 1);
    run(2, 3, 5, 1'b1, 1'b1, 0);
  endtask

  initial begin
    bit wd = 0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    fork
      tests();
      begin repeat (150000) @(posedge clk); wd = 1; end
    join_any
    disable fork;
    if (wd) begin
      failures++;
      checks++;
      $display("FAIL watchdog actual=hung expected=finished");
    end
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule